// File: doc/BRIEF.md
# Latched Serial-to-Parallel Output Expander

This block adds output pins to a microcontroller through four wires: serial data, a shift clock, a strobe and an active-low clear. A shift register takes in serial data on every rising edge of the shift clock. A separate latch stage drives the parallel outputs. While the strobe is high, the latch holds its value, so a new word can be shifted in without disturbing the outputs. While the strobe is low, the latch is transparent and the outputs follow the shift register. The clear pin forces the latch, and so the outputs, to zero. It leaves the shift register untouched.

A cascade output carries the oldest bit of the shift register, so further expanders can be chained from it. It does not depend on strobe or clear. All four pins are asynchronous to the block. Each passes through a two-flop synchroniser clocked by the system clock `clk_i`, and the shift-clock edge is detected from the synchronised level. Any pin change reaches the outputs within four system clocks.

Top module: `sipo_expander`

## Requirements
- R1: A rising edge on `sclk_i` shifts `sdata_i` into stage 0 and moves every stage k to stage k+1. A falling edge or a steady level shifts nothing.
- R2: Shifting happens on every rising edge of `sclk_i` at either strobe level.
- R3: While `strobe_i` is high and `clear_ni` is high, `par_o` holds its value while data is shifted.
- R4: While `strobe_i` is low and `clear_ni` is high, `par_o` equals the shift register contents. This includes the transfer when the strobe falls and every shift while it stays low. `par_o` is valid within 4 `clk_i` cycles of the pin change.
- R5: While `clear_ni` is low, `par_o` is all zeros whatever the strobe and clock. After clear rises with the strobe high, `par_o` stays zero.
- R6: Clear does not alter the shift register contents.
- R7: `cascade_o` is always the oldest stage (stage WIDTH-1), independent of strobe and clear.
- R8: Bit order is as follows. The first of WIDTH shifted bits appears on `par_o[WIDTH-1]`, and the most recent bit appears on `par_o[0]`.
- R9: With `rst_ni` low, the shift register and latch are zero, so `par_o` and `cascade_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| sdata_i | input | 1 | Serial data pin |
| sclk_i | input | 1 | Shift clock pin, rising edge shifts |
| strobe_i | input | 1 | Latch control: high holds, low is transparent |
| clear_ni | input | 1 | Active-low clear of the output latch |
| par_o | output | WIDTH | Parallel outputs, bit 0 is the newest bit |
| cascade_o | output | 1 | Oldest shift stage, for chaining |

## Verification
The hardest case to reach from the ports is to show that clear left the shift register intact. The outputs are zero during clear and stay zero afterwards while the strobe is high, so the register contents are hidden. The stimulus therefore loads a known word, pulses clear, releases it with the strobe high, and confirms that the outputs are still zero. It then drops the strobe, so that the unchanged word must reappear on the outputs. Shifting with the strobe low checks transparency edge by edge, and a sweep over all 256 byte values checks order, hold and cascade.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  localparam int SYNC_DEPTH = 2;

  typedef struct packed {
    logic sclk;
    logic sdata;
    logic strobe;
    logic clear_n;
  } pins_t;

  localparam int PINS_W = $bits(pins_t);
endpackage

// File: rtl/sipo_sync.sv
module sipo_sync #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= d_i;
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= stage_q[g-1];
    end
  end

  assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/sipo_shift.sv
module sipo_shift #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_s_i,
  input  logic             sdata_s_i,
  output logic             rise_o,
  output logic [WIDTH-1:0] shift_o
);
  logic             sclk_d_q;
  logic [WIDTH-1:0] shift_q;

  assign rise_o = sclk_s_i & ~sclk_d_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sclk_d_q <= 1'b0;
    else         sclk_d_q <= sclk_s_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     shift_q <= '0;
    else if (rise_o) shift_q <= {shift_q[WIDTH-2:0], sdata_s_i};

  assign shift_o = shift_q;
endmodule

// File: rtl/sipo_latch.sv
module sipo_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_s_i,
  input  logic             clear_ns_i,
  input  logic [WIDTH-1:0] shift_i,
  output logic [WIDTH-1:0] lat_o
);
  logic [WIDTH-1:0] lat_q;

  // clear wins over strobe; strobe low means transparent
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)          lat_q <= '0;
    else if (!clear_ns_i) lat_q <= '0;
    else if (!strobe_s_i) lat_q <= shift_i;

  assign lat_o = lat_q;
endmodule

// File: rtl/sipo_expander.sv
module sipo_expander #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sdata_i,
  input  logic             sclk_i,
  input  logic             strobe_i,
  input  logic             clear_ni,
  output logic [WIDTH-1:0] par_o,
  output logic             cascade_o
);
  import sipo_pkg::*;

  pins_t            pins_raw, pins_s;
  logic             sclk_rise;
  logic [WIDTH-1:0] shift_q;
  logic             strobe_s, clear_s;

  assign pins_raw = '{sclk: sclk_i, sdata: sdata_i, strobe: strobe_i, clear_n: clear_ni};

  sipo_sync #(.WIDTH(PINS_W), .DEPTH(SYNC_DEPTH)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  assign strobe_s = pins_s.strobe;
  assign clear_s  = pins_s.clear_n;

  sipo_shift #(.WIDTH(WIDTH)) i_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_s_i (pins_s.sclk),
    .sdata_s_i(pins_s.sdata),
    .rise_o   (sclk_rise),
    .shift_o  (shift_q)
  );

  sipo_latch #(.WIDTH(WIDTH)) i_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_s_i(strobe_s),
    .clear_ns_i(clear_s),
    .shift_i   (shift_q),
    .lat_o     (par_o)
  );

  assign cascade_o = shift_q[WIDTH-1];
endmodule

// File: rtl/sipo_expander_chk.sv
module sipo_expander_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_s,
  input logic             stb_s,
  input logic             rise,
  input logic [WIDTH-1:0] shift_q,
  input logic [WIDTH-1:0] par_o
);
  AST_SHIFT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> shift_q[WIDTH-1:1] == $past(shift_q[WIDTH-2:0])); // R1
  AST_NO_EDGE_NO_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise |=> $stable(shift_q)); // R6
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_s && stb_s) |=> $stable(par_o)); // R3
  AST_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_s && !stb_s) |=> par_o == $past(shift_q)); // R4
  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_s |=> par_o == '0); // R5
endmodule

bind sipo_expander sipo_expander_chk #(.WIDTH(WIDTH)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .clr_s  (clear_s),
  .stb_s  (strobe_s),
  .rise   (sclk_rise),
  .shift_q(shift_q),
  .par_o  (par_o)
);

// File: tb/test_sipo_expander.sv
module test_sipo_expander;
  localparam int W = 8;

  logic         clk = 0, rst_ni = 0;
  logic         sdata = 0, sclk = 0, strobe = 1, clear_n = 1;
  logic [W-1:0] par;
  logic         casc;
  int           errors = 0, checks = 0;
  logic [W-1:0] m_shift = '0, m_lat = '0;
  bit           done = 0;

  always #5 clk = ~clk;

  sipo_expander #(.WIDTH(W)) i_sipo_expander (
    .clk_i(clk), .rst_ni(rst_ni), .sdata_i(sdata), .sclk_i(sclk),
    .strobe_i(strobe), .clear_ni(clear_n), .par_o(par), .cascade_o(casc)
  );

  task automatic settle();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_latch();
    if (!clear_n)     m_lat = '0;
    else if (!strobe) m_lat = m_shift;
  endtask

  task automatic shift_bit(logic b);
    sdata = b; settle();
    sclk = 1;
    m_shift = {m_shift[W-2:0], b};
    model_latch();
    settle();
    sclk = 0; settle();
  endtask

  task automatic set_strobe(logic v);
    strobe = v; model_latch(); settle();
  endtask

  task automatic set_clear(logic v);
    clear_n = v; model_latch(); settle();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset par", par, '0);
    check("R9 reset cascade", {{(W-1){1'b0}}, casc}, '0);
    rst_ni = 1; settle();

    // R1 R3 R7 R8: sweep every byte, shift with strobe high, then transfer
    for (int v = 0; v < 256; v++) begin
      logic [W-1:0] prev;
      prev = m_lat;
      for (int i = W - 1; i >= 0; i--) shift_bit(v[i]);
      check("R3 hold while strobe high", par, prev);
      check("R7 cascade oldest", {{(W-1){1'b0}}, casc}, {{(W-1){1'b0}}, v[W-1]});
      set_strobe(0);
      check("R8 R1 transfer order", par, W'(v));
      set_strobe(1);
    end

    // R1: falling edge and idle level shift nothing
    sdata = 1; settle(); sclk = 1; settle();
    m_shift = {m_shift[W-2:0], 1'b1};
    sdata = 0; settle(); sclk = 0; settle();
    set_strobe(0);
    check("R1 no shift on fall", par, m_shift);
    set_strobe(1);

    // R2 R4: transparent follow while strobe low
    set_strobe(0);
    for (int i = 0; i < 10; i++) begin
      shift_bit(i % 3 == 0);
      check("R2 R4 follow per edge", par, m_shift);
      check("R7 cascade while low", {{(W-1){1'b0}}, casc}, {{(W-1){1'b0}}, m_shift[W-1]});
    end
    set_strobe(1);

    // R5 R6: clear hides, shift register survives
    for (int i = 0; i < W; i++) shift_bit(i[0]);
    set_strobe(0); set_strobe(1);
    check("R4 loaded", par, m_shift);
    set_clear(0);
    check("R5 clear zero", par, '0);
    check("R7 cascade during clear", {{(W-1){1'b0}}, casc}, {{(W-1){1'b0}}, m_shift[W-1]});
    set_strobe(0);
    check("R5 clear wins over strobe", par, '0);
    shift_bit(1);
    check("R5 clear during shifting", par, '0);
    set_strobe(1);
    set_clear(1);
    check("R5 stays zero after release", par, '0);
    check("R5 model", par, m_lat);
    set_strobe(0);
    check("R6 shift register intact", par, m_shift);
    set_strobe(1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule